// File: doc/BRIEF.md
# Pipeline Interrupt Acceptance Gate

This block decides the cycle in which a pipelined core takes an external interrupt from its interrupt controller. Instructions that turn the master interrupt-enable flag on or off, and the interrupt marker the gate injects, are all counted from the moment they pass decode until they retire. While any of them is in flight, the effect on the flag is not yet settled, so the gate refuses new interrupts. When nothing is in flight and the retired flag is set, the gate grants a held request. The marker is then placed in the decode slot and a purge of the fetch buffer is requested in the same cycle. The gate does not drain the pipeline to settle the enable state.

A flush from a branch mispredict or an exception supplies the number of squashed enable-changing operations, and the gate removes them from its count. Exceptions and flushes do not touch the flag. The flag changes only when an enable instruction, a disable instruction or a marker retires.

Top module: `irq_accept_gate`

## Requirements
- R1: After reset the enable flag is 0, the in-flight count is 0 and no grant is given.
- R2: Outside a flush cycle, `dec_evt` raises the in-flight count by one.
- R3: `ret_evt` lowers the count by one. When `dec_evt` and `ret_evt` come together outside a flush, the count stays unchanged.
- R4: `irq_gnt` is high only in a cycle where `irq_req` is high, the count is 0, the flag is 1, `flush` is low and `dec_evt` is low. `inj_marker` and `fetch_purge` are high exactly in the grant cycle.
- R5: A grant adds one to the count, because the injected marker is in flight. A held request therefore gets a single-cycle grant.
- R6: The flag changes only on `ret_evt`, according to `ret_kind`. 2'b01 (enable) sets it, 2'b10 (disable) clears it, and 2'b11 (interrupt marker) clears it.
- R7: In a flush cycle the new count is the old count minus `ret_evt` minus `flush_cnt`, floored at 0. A `dec_evt` in the flush cycle is squashed and not counted.
- R8: A flush, including an exception flush, leaves the flag unchanged. A retire in the same cycle still updates the flag.
- R9: The count saturates at 2^CNT_W-1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_evt | input | 1 | An enable-changing instruction passes decode |
| ret_evt | input | 1 | An enable-changing operation retires |
| ret_kind | input | 2 | Kind of the retiring operation: 01 enable, 10 disable, 11 marker |
| flush | input | 1 | Pipeline flush (mispredict or exception) |
| flush_cnt | input | CNT_W | Number of squashed, unretired enable-changing operations |
| irq_req | input | 1 | Interrupt request from the controller, held until granted |
| irq_gnt | output | 1 | Grant pulse to the controller |
| inj_marker | output | 1 | Insert the interrupt marker at decode this cycle |
| fetch_purge | output | 1 | Purge the fetch buffer this cycle |
| ie_flag | output | 1 | Retired master interrupt-enable flag |
| pend_cnt | output | CNT_W | In-flight enable-changing operation count |

## Verification
The bench holds a request while an enable instruction is in flight. A gate that looked only at the flag would grant too early. It then keeps the request held after a grant. A gate that did not count its own marker would grant a second time. It presents a decode event together with a retire, and a flush whose squash count is larger than the count. A wrong counter would drift in the first case and wrap to a large value in the second. It also retires an enable instruction during a flush and checks that the flag still changes, and it drives the count into saturation. A design that wraps at saturation would reopen acceptance while operations are still in flight.

// File: rtl/iag_pkg.sv
package iag_pkg;
    typedef enum logic [1:0] {
        RK_NONE    = 2'b00,
        RK_ENABLE  = 2'b01,
        RK_DISABLE = 2'b10,
        RK_MARKER  = 2'b11
    } ret_kind_e;
endpackage

// File: rtl/iag_count.sv
module iag_count #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             inc,
    input  logic             dec,
    input  logic             flush,
    input  logic [CNT_W-1:0] flush_cnt,
    output logic [CNT_W-1:0] cnt_d
);
    localparam int WW = CNT_W + 2;
    localparam logic [WW-1:0] CNT_MAX = {2'b00, {CNT_W{1'b1}}};

    logic [WW-1:0] up;
    logic [WW-1:0] down;
    logic [WW-1:0] res;

    always_comb begin
        // a decode event in a flush cycle is squashed (R7)
        up   = {2'b00, cnt_q} + {{(WW-1){1'b0}}, (inc & ~flush)};
        down = {{(WW-1){1'b0}}, dec} + (flush ? {2'b00, flush_cnt} : '0);
        if (up >= down) res = up - down;
        else            res = '0;
        if (res > CNT_MAX) res = CNT_MAX;   // saturate (R9)
        cnt_d = res[CNT_W-1:0];
    end
endmodule

// File: rtl/iag_flag.sv
module iag_flag
    import iag_pkg::*;
(
    input  logic       ie_q,
    input  logic       ret_evt,
    input  logic [1:0] ret_kind,
    output logic       ie_d
);
    always_comb begin
        ie_d = ie_q;
        if (ret_evt) begin
            unique case (ret_kind)
                RK_ENABLE:  ie_d = 1'b1;
                RK_DISABLE: ie_d = 1'b0;
                RK_MARKER:  ie_d = 1'b0;
                default:    ie_d = ie_q;
            endcase
        end
    end
endmodule

// File: rtl/iag_grant.sv
module iag_grant #(
    parameter int CNT_W = 4
) (
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             ie_q,
    input  logic             irq_req,
    input  logic             flush,
    input  logic             dec_evt,
    output logic             gnt
);
    logic settled;

    always_comb begin
        settled = (cnt_q == '0) && ie_q;
        // decode slot must be free for the marker, and no flush this cycle
        gnt = irq_req && settled && !flush && !dec_evt;
    end
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_evt,
    input  logic             ret_evt,
    input  logic [1:0]       ret_kind,
    input  logic             flush,
    input  logic [CNT_W-1:0] flush_cnt,
    input  logic             irq_req,
    output logic             irq_gnt,
    output logic             inj_marker,
    output logic             fetch_purge,
    output logic             ie_flag,
    output logic [CNT_W-1:0] pend_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ie;
    } gate_st_t;

    gate_st_t st_d, st_q;

    logic             gnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             ie_nxt;

    iag_grant #(.CNT_W(CNT_W)) u_grant (
        .cnt_q   (st_q.cnt),
        .ie_q    (st_q.ie),
        .irq_req (irq_req),
        .flush   (flush),
        .dec_evt (dec_evt),
        .gnt     (gnt)
    );

    // the injected marker counts as an in-flight enable-changing operation
    iag_count #(.CNT_W(CNT_W)) u_count (
        .cnt_q     (st_q.cnt),
        .inc       (dec_evt | gnt),
        .dec       (ret_evt),
        .flush     (flush),
        .flush_cnt (flush_cnt),
        .cnt_d     (cnt_nxt)
    );

    iag_flag u_flag (
        .ie_q     (st_q.ie),
        .ret_evt  (ret_evt),
        .ret_kind (ret_kind),
        .ie_d     (ie_nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
        st_d.ie  = ie_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.ie  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_gnt     = gnt;
    assign inj_marker  = gnt;
    assign fetch_purge = gnt;
    assign ie_flag     = st_q.ie;
    assign pend_cnt    = st_q.cnt;
endmodule

// File: rtl/iag_checker.sv
module iag_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_evt,
    input logic             ret_evt,
    input logic [1:0]       ret_kind,
    input logic             flush,
    input logic [CNT_W-1:0] flush_cnt,
    input logic             irq_req,
    input logic             irq_gnt,
    input logic             inj_marker,
    input logic             fetch_purge,
    input logic             ie_flag,
    input logic [CNT_W-1:0] pend_cnt
);
    assert_gnt_safe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gnt |-> (irq_req && pend_cnt == '0 && ie_flag && !flush && !dec_evt));

    assert_gnt_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gnt |=> !irq_gnt);

    assert_marker_counted_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_gnt && !ret_evt) |=> (pend_cnt == 1));

    assert_flag_retire_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_evt |=> (ie_flag == $past(ie_flag)));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_evt && ret_kind == 2'b01) |=> ie_flag);

    assert_flush_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !ret_evt && flush_cnt >= pend_cnt) |=> (pend_cnt == '0));
endmodule

bind irq_accept_gate iag_checker #(.CNT_W(CNT_W)) u_iag_checker (.*);

// File: tb/irq_accept_gate_bench.sv
`timescale 1ns/1ps
module irq_accept_gate_bench;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             dec_evt, ret_evt, flush, irq_req;
    logic [1:0]       ret_kind;
    logic [CNT_W-1:0] flush_cnt;
    logic             irq_gnt, inj_marker, fetch_purge, ie_flag;
    logic [CNT_W-1:0] pend_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_accept_gate #(.CNT_W(CNT_W)) u_irq_accept_gate (
        .clk, .rst_n, .dec_evt, .ret_evt, .ret_kind, .flush, .flush_cnt,
        .irq_req, .irq_gnt, .inj_marker, .fetch_purge, .ie_flag, .pend_cnt
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic d, input logic r, input logic [1:0] k,
                         input logic f, input logic [3:0] fc, input logic q);
        dec_evt = d; ret_evt = r; ret_kind = k; flush = f; flush_cnt = fc; irq_req = q;
    endtask

    // fields: dec ret kind[2] flush fcnt[4] req | gnt cnt[4] ie
    localparam int NV = 21;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd0,1'b0}, // R4 flag 0: no grant
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd1,1'b0}, // R2
        {1'b0,1'b1,2'd1,1'b0,4'd0,1'b1, 1'b0,4'd0,1'b1}, // R3 R6 enable
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b1,4'd1,1'b1}, // R4 R5 grant
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd1,1'b1}, // R5 single pulse
        {1'b0,1'b1,2'd3,1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0}, // R6 marker clears
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b0, 1'b0,4'd1,1'b0}, // R2
        {1'b0,1'b1,2'd1,1'b0,4'd0,1'b0, 1'b0,4'd0,1'b1}, // R6
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd1,1'b1}, // R4 decode busy
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd1,1'b1}, // R4 in flight
        {1'b1,1'b1,2'd2,1'b0,4'd0,1'b1, 1'b0,4'd1,1'b0}, // R3 same cycle, R6 disable
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b0, 1'b0,4'd2,1'b0}, // R2
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b0, 1'b0,4'd3,1'b0}, // R2
        {1'b1,1'b0,2'd0,1'b1,4'd5,1'b0, 1'b0,4'd0,1'b0}, // R7 floor, squashed decode
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b0, 1'b0,4'd1,1'b0}, // R2
        {1'b0,1'b1,2'd1,1'b1,4'd0,1'b0, 1'b0,4'd0,1'b1}, // R8 retire during flush
        {1'b1,1'b0,2'd0,1'b0,4'd0,1'b0, 1'b0,4'd1,1'b1}, // R2
        {1'b0,1'b0,2'd0,1'b1,4'd1,1'b1, 1'b0,4'd0,1'b1}, // R4 flush blocks, R8 flag kept
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b1,4'd1,1'b1}, // R4 grant
        {1'b0,1'b1,2'd3,1'b0,4'd0,1'b0, 1'b0,4'd0,1'b0}, // R6 marker retire
        {1'b0,1'b0,2'd0,1'b0,4'd0,1'b1, 1'b0,4'd0,1'b0}  // R4 flag 0
    };

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #100us;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 2'd0, 0, 4'd0, 1);
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(pend_cnt), 0);
        chk("R1 reset flag", int'(ie_flag), 0);
        chk("R1 reset grant", int'(irq_gnt), 0);
        rst_n = 1'b1;
        drive(0, 0, 2'd0, 0, 4'd0, 0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            drive(v[15], v[14], v[13:12], v[11], v[10:7], v[6]);
            #1;
            chk($sformatf("R4 vec %0d grant", i), int'(irq_gnt), int'(v[5]));
            chk($sformatf("R4 vec %0d purge", i), int'(fetch_purge), int'(v[5]));
            chk($sformatf("R4 vec %0d marker", i), int'(inj_marker), int'(v[5]));
            @(negedge clk);
            chk($sformatf("R2/R3/R7 vec %0d count", i), int'(pend_cnt), int'(v[4:1]));
            chk($sformatf("R6/R8 vec %0d flag", i), int'(ie_flag), int'(v[0]));
        end

        // R9: saturation
        drive(1, 0, 2'd0, 0, 4'd0, 0);
        repeat (17) @(negedge clk);
        chk("R9 saturate", int'(pend_cnt), 15);
        // R7: retire and flush together
        drive(0, 1, 2'd0, 1, 4'd3, 0);
        @(negedge clk);
        chk("R7 flush minus retire", int'(pend_cnt), 11);
        // R7: decode event squashed by flush
        drive(1, 0, 2'd0, 1, 4'd0, 0);
        @(negedge clk);
        chk("R7 squashed decode", int'(pend_cnt), 11);
        // R1: reset mid-run
        drive(0, 0, 2'd0, 0, 4'd0, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset again count", int'(pend_cnt), 0);
        #1;
        chk("R1 no grant after reset", int'(irq_gnt), 0);
        @(negedge clk);
        finish_run();
    end
endmodule